// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block is one general-purpose I/O port with a parameterised number of pins (eight by default) behind a small register bus. Software sets the output level of each pin, picks each pin's direction, and turns on an input pull-up per pin. It reads back a port view in which every output pin shows its latched output value and every input pin shows its synchronised pad level. Bus writes are single-cycle and take effect on the clock edge where the strobe is seen. Read data is combinational from the addressed register.

Two reset classes are kept apart. The synchronous active-low power-on reset and the hardware-standby input clear the output, direction and pull-up registers. The manual-reset and software-standby inputs keep every register and freeze the sampled pin view. While either of those is high, bus writes are ignored. Hardware standby takes priority over both.

Register addresses on the two-bit `addr` bus: 0 is the output data register, 1 is the direction register, 2 is the read-only port view, and 3 is the pull-up register.

Top module: `gpio_port_ctrl`

## Requirements
- R1: A write at address 0 loads `wdata` into the output data register on that clock edge. After the edge, `pad_out` and a read at address 0 both show the new value.
- R2: A write at address 1 loads the direction register. After the edge, a read at address 1 shows it and `pad_oe` equals it. A bit value of 1 makes that pin an output.
- R3: A write at address 3 loads the pull-up register, which reads back at address 3. For each bit, `pad_pu` is 1 only when the pull-up bit is 1 and the direction bit is 0.
- R4: For each bit, a read at address 2 returns the output data register bit when the direction bit is 1. It returns the sampled pad level when the direction bit is 0.
- R5: A write at address 2 changes none of the output data, direction or pull-up registers.
- R6: At a rising edge with `rst_n` low, the output data, direction and pull-up registers are cleared to zero, and so are the synchroniser and the sampled pin view.
- R7: At a rising edge with `hw_stby` high, the output data, direction and pull-up registers are cleared to zero, even if a write or `man_rst`/`sw_stby` is present. Pad sampling keeps running.
- R8: While `man_rst` or `sw_stby` is high (and `hw_stby` low), all three registers keep their contents, bus writes are ignored, and the sampled pin view at address 2 stays frozen.
- R9: A change on `pad_in` appears in an address-2 read of an input pin after exactly SYNC_STAGES+1 rising edges, which is 3 with the defaults. It does not appear after fewer.
- R10: `rdata` follows `addr` within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset; clears the registers |
| hw_stby | input | 1 | Hardware standby; clears the registers |
| man_rst | input | 1 | Manual reset; keeps the registers and freezes the pin view |
| sw_stby | input | 1 | Software standby; keeps the registers and freezes the pin view |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | 2 | Register select |
| wdata | input | W | Write data |
| rdata | output | W | Read data from the addressed register |
| pad_in | input | W | Pad input levels (asynchronous) |
| pad_out | output | W | Per-pin output value |
| pad_oe | output | W | Per-pin output enable |
| pad_pu | output | W | Per-pin pull-up enable |

## Verification
The bench builds the block with its defaults: W = 8 and SYNC_STAGES = 2. With eight pins, every value of the output data, direction and pull-up registers fits in a 256-step sweep, so all of them are covered. The port-view mixing is swept over every direction pattern against two complementary pad and data patterns. With two synchroniser stages, the exact three-edge pad latency and the freeze, keep and clear behaviour of each reset class can be checked edge by edge.

// File: rtl/gpio_port_pkg.sv
// Package: gpio_port_pkg
// Shared register selector encoding for the GPIO port controller.
// Assumes a two-bit register address bus.
package gpio_port_pkg;
    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_PIN  = 2'd2,
        SEL_PULL = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio_regfile.sv
// Module: gpio_regfile
// Holds the output data, direction and pull-up registers.
// A clear request (power-on reset or hardware standby) zeroes them.
// A hold request (manual reset or software standby) blocks writes.
// Assumes the clear and hold requests are synchronous to clk.
module gpio_regfile
    import gpio_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         hold,
    input  logic         wr_en,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] data_q,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] pull_q
);
    logic wr_ok;

    // Writes count only when the registers are neither cleared nor held
    always_comb wr_ok = wr_en && !clr && !hold;

    // Output data register
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            data_q <= '0;
        else if (wr_ok && reg_sel_e'(addr) == SEL_DATA)
            data_q <= wdata;
    end

    // Direction register
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            dir_q <= '0;
        else if (wr_ok && reg_sel_e'(addr) == SEL_DIR)
            dir_q <= wdata;
    end

    // Pull-up enable register
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            pull_q <= '0;
        else if (wr_ok && reg_sel_e'(addr) == SEL_PULL)
            pull_q <= wdata;
    end
endmodule

// File: rtl/gpio_in_sampler.sv
// Module: gpio_in_sampler
// Synchronises the asynchronous pad inputs through STAGES flops.
// It then captures the result into the pin view register, which stays
// unchanged while freeze is high. Everything clears on power-on reset.
// Assumes STAGES >= 1.
module gpio_in_sampler #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         freeze,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] pin_q
);
    logic [W-1:0] chain [STAGES];

    // First synchroniser stage
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= pad_in;
    end

    // Remaining synchroniser stages
    for (genvar s = 1; s < STAGES; s++) begin : g_sync
        always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
        end
    end

    // Pin view capture, frozen on request
    always_ff @(posedge clk) begin
        if (!rst_n)       pin_q <= '0;
        else if (!freeze) pin_q <= chain[STAGES-1];
    end
endmodule

// File: rtl/gpio_read_mux.sv
// Module: gpio_read_mux
// Builds the per-bit port view and selects the read data.
// Purely combinational.
module gpio_read_mux
    import gpio_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [1:0]   addr,
    input  logic [W-1:0] data_q,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] pull_q,
    input  logic [W-1:0] pin_q,
    output logic [W-1:0] rdata
);
    logic [W-1:0] port_view;

    // Each bit shows latched data when the pin is an output, else the pin level
    for (genvar b = 0; b < W; b++) begin : g_bit
        always_comb port_view[b] = dir_q[b] ? data_q[b] : pin_q[b];
    end

    // Select the addressed register
    always_comb begin
        unique case (reg_sel_e'(addr))
            SEL_DATA: rdata = data_q;
            SEL_DIR:  rdata = dir_q;
            SEL_PIN:  rdata = port_view;
            SEL_PULL: rdata = pull_q;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_port_ctrl.sv
// Module: gpio_port_ctrl (top)
// W-pin bidirectional GPIO port with a register bus, two reset classes,
// pad input synchronisation and per-pin pull-up gating.
// Assumes all control inputs except pad_in are synchronous to clk.
module gpio_port_ctrl #(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hw_stby,
    input  logic         man_rst,
    input  logic         sw_stby,
    input  logic         wr_en,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_pu
);
    logic         hold;
    logic         freeze;
    logic [W-1:0] data_q;
    logic [W-1:0] dir_q;
    logic [W-1:0] pull_q;
    logic [W-1:0] pin_q;

    // Retention class: manual reset or software standby
    always_comb hold = man_rst || sw_stby;
    // Hardware standby overrides the freeze so the pins stay visible
    always_comb freeze = hold && !hw_stby;

    gpio_regfile #(.W(W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (hw_stby),
        .hold   (hold),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .data_q (data_q),
        .dir_q  (dir_q),
        .pull_q (pull_q)
    );

    gpio_in_sampler #(.W(W), .STAGES(SYNC_STAGES)) u_samp (
        .clk    (clk),
        .rst_n  (rst_n),
        .freeze (freeze),
        .pad_in (pad_in),
        .pin_q  (pin_q)
    );

    gpio_read_mux #(.W(W)) u_rmux (
        .addr   (addr),
        .data_q (data_q),
        .dir_q  (dir_q),
        .pull_q (pull_q),
        .pin_q  (pin_q),
        .rdata  (rdata)
    );

    // Pad drive: value, enable, and pull-up only on input pins
    always_comb begin
        pad_out = data_q;
        pad_oe  = dir_q;
        pad_pu  = pull_q & ~dir_q;
    end
endmodule

// File: rtl/gpio_port_chk.sv
// Module: gpio_port_chk
// Port-level checker for gpio_port_ctrl, attached through bind.
module gpio_port_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         hw_stby,
    input logic         man_rst,
    input logic         sw_stby,
    input logic         wr_en,
    input logic [1:0]   addr,
    input logic [W-1:0] wdata,
    input logic [W-1:0] rdata,
    input logic [W-1:0] pad_out,
    input logic [W-1:0] pad_oe,
    input logic [W-1:0] pad_pu
);
    logic held;
    always_comb held = (man_rst || sw_stby) && !hw_stby;

    // R1
    data_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd0 && !man_rst && !sw_stby && !hw_stby)
        |=> pad_out == $past(wdata));

    // R3
    pull_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd3 && !man_rst && !sw_stby && !hw_stby)
        |=> pad_pu == ($past(wdata) & ~pad_oe));

    // R4
    out_pin_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 2'd2) |-> ((rdata & pad_oe) == (pad_out & pad_oe)));

    // R7
    hw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby |=> (pad_out == '0 && pad_oe == '0 && pad_pu == '0));

    // R8
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> ($stable(pad_out) && $stable(pad_oe) && $stable(pad_pu)));

    // R8
    hold_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held && $past(held) && $past(rst_n) && addr == 2'd2 && $past(addr) == 2'd2)
        |-> $stable(rdata));
endmodule

bind gpio_port_ctrl gpio_port_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .hw_stby (hw_stby),
    .man_rst (man_rst),
    .sw_stby (sw_stby),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .pad_out (pad_out),
    .pad_oe  (pad_oe),
    .pad_pu  (pad_pu)
);

// File: tb/tb_gpio_port_ctrl.sv
module tb_gpio_port_ctrl;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         hw_stby = 1'b0;
    logic         man_rst = 1'b0;
    logic         sw_stby = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   addr = 2'd0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic [W-1:0] pad_in = '0;
    logic [W-1:0] pad_out;
    logic [W-1:0] pad_oe;
    logic [W-1:0] pad_pu;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    gpio_port_ctrl #(.W(W), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .man_rst(man_rst),
        .sw_stby(sw_stby), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input logic [W-1:0] exp);
        addr = a;
        #1;
        chk(req, rdata, exp);
    endtask

    function automatic logic [W-1:0] view(input logic [W-1:0] d, input logic [W-1:0] r,
                                          input logic [W-1:0] p);
        return (r & d) | (~r & p);
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        // R6: power-on reset with pads high
        pad_in = 8'hFF;
        repeat (3) tick();
        chk("R6 data", pad_out, 8'h00);
        chk("R6 dir", pad_oe, 8'h00);
        chk("R6 pull", pad_pu, 8'h00);
        rd_chk("R6 pin view", 2'd2, 8'h00);
        rst_n = 1'b1;

        // R9: pad level reaches the view after exactly three edges
        tick(); tick();
        rd_chk("R9 two edges", 2'd2, 8'h00);
        tick();
        rd_chk("R9 three edges", 2'd2, 8'hFF);
        pad_in = 8'h5A;
        tick(); tick();
        rd_chk("R9 two edges b", 2'd2, 8'hFF);
        tick();
        rd_chk("R9 three edges b", 2'd2, 8'h5A);

        // R1 and R10: sweep every data value
        for (int v = 0; v < 256; v++) begin
            wr(2'd0, W'(v));
            chk("R1 pad_out", pad_out, W'(v));
            rd_chk("R10 readback data", 2'd0, W'(v));
        end

        // R2 and R4: sweep every direction pattern against two pad/data pairs
        for (int pass = 0; pass < 2; pass++) begin
            logic [W-1:0] d, p;
            d = pass ? 8'h5A : 8'hA5;
            p = pass ? 8'hC3 : 8'h3C;
            pad_in = p;
            wr(2'd0, d);
            repeat (3) tick();
            for (int r = 0; r < 256; r++) begin
                wr(2'd1, W'(r));
                chk("R2 pad_oe", pad_oe, W'(r));
                rd_chk("R2 readback dir", 2'd1, W'(r));
                rd_chk("R4 port view", 2'd2, view(d, W'(r), p));
            end
        end

        // R3: sweep pull-up values with mixed direction
        wr(2'd1, 8'h0F);
        for (int u = 0; u < 256; u++) begin
            wr(2'd3, W'(u));
            chk("R3 pad_pu", pad_pu, W'(u) & 8'hF0);
            rd_chk("R3 readback pull", 2'd3, W'(u));
        end

        // R5: write to the read-only address changes nothing
        wr(2'd0, 8'h96); wr(2'd1, 8'h33); wr(2'd3, 8'hCC);
        pad_in = 8'h0F;
        repeat (3) tick();
        wr(2'd2, 8'h69);
        chk("R5 data kept", pad_out, 8'h96);
        chk("R5 dir kept", pad_oe, 8'h33);
        rd_chk("R5 pull kept", 2'd3, 8'hCC);
        rd_chk("R5 view", 2'd2, view(8'h96, 8'h33, 8'h0F));

        // R8: manual reset keeps registers, blocks writes, freezes view
        man_rst = 1'b1;
        pad_in = 8'hF0;
        wr(2'd0, 8'h11); wr(2'd1, 8'h22); wr(2'd3, 8'h44);
        repeat (4) tick();
        chk("R8 man data", pad_out, 8'h96);
        chk("R8 man dir", pad_oe, 8'h33);
        chk("R8 man pull", pad_pu, 8'hCC & ~8'h33);
        rd_chk("R8 man view frozen", 2'd2, view(8'h96, 8'h33, 8'h0F));
        man_rst = 1'b0;
        repeat (2) tick();
        rd_chk("R8 view resumes", 2'd2, view(8'h96, 8'h33, 8'hF0));

        // R8: software standby behaves the same
        sw_stby = 1'b1;
        pad_in = 8'h00;
        wr(2'd0, 8'hEE);
        repeat (4) tick();
        chk("R8 sw data", pad_out, 8'h96);
        rd_chk("R8 sw view frozen", 2'd2, view(8'h96, 8'h33, 8'hF0));
        sw_stby = 1'b0;
        repeat (2) tick();
        rd_chk("R8 sw resumes", 2'd2, view(8'h96, 8'h33, 8'h00));

        // R7: hardware standby clears even during a hold and a write
        sw_stby = 1'b1; hw_stby = 1'b1;
        pad_in = 8'hA7;
        wr(2'd0, 8'h77);
        chk("R7 data", pad_out, 8'h00);
        chk("R7 dir", pad_oe, 8'h00);
        rd_chk("R7 pull", 2'd3, 8'h00);
        repeat (3) tick();
        rd_chk("R7 sampling runs", 2'd2, 8'hA7);
        hw_stby = 1'b0; sw_stby = 1'b0;

        // R6: power-on reset after activity clears again
        wr(2'd0, 8'h3C); wr(2'd1, 8'hFF); wr(2'd3, 8'h81);
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        chk("R6 data again", pad_out, 8'h00);
        chk("R6 dir again", pad_oe, 8'h00);
        rd_chk("R6 pull again", 2'd3, 8'h00);

        summary();
    end
endmodule